// File: doc/BRIEF.md
# Oscillator Warm-up Timer

This block keeps a freshly enabled oscillator out of use until it has run for a programmed number of its own clock periods. The block runs on the clock of the oscillator being warmed up. Software programs only the upper part of a compare value; the lowest bits of the compare value are always zero, so the target count is a multiple of sixteen. A count begins when software pulses a start request or when the power-mode controller signals an exit from the deep stop mode. When the count is started by that mode exit, the block reports that the internal high-speed oscillator is the count source, whatever software had chosen.

While the count runs, the busy output is high. Software reads this as a start bit that reads back 1 and polls it until it returns to 0. When the counter reaches the compare value, the block raises a one-cycle done pulse, drops busy and freezes the counter. One parameter set gives the 16-bit high-speed variant, whose programmable field resets to 0x800. A wider setting gives the 19-bit low-speed variant. All control pins are plain level or pulse signals: nothing streams through the block, so no valid/ready handshake applies.

Top module: `wut_top`

## Requirements
- R1: After reset, busy and done are 0, count is 0, cnt_src is 0 (external source), and the programmable field holds RST_FIELD. With the defaults, this makes cmp_value 0x8000.
- R2: cmp_value equals the programmed field shifted left by LOW_BITS (4) bits. Its bits [3:0] are always zero.
- R3: A sw_start pulse while idle raises busy and clears count to 0 on the next clock edge. cnt_src then takes the value of sw_src (0 = external, 1 = internal).
- R4: A wake_start pulse while idle starts the count in the same way, and cnt_src becomes 1 (internal oscillator). This holds even if sw_start is also high with sw_src = 0.
- R5: While busy, count rises by one per clock. Busy stays high for exactly cmp_value+1 cycles. done is high for exactly one cycle, in the first cycle in which busy is low again.
- R6: After completion, count holds at cmp_value until the next start.
- R7: A cfg_we write while busy leaves the programmed field unchanged.
- R8: A start request (sw_start or wake_start) while busy neither restarts the count nor changes cnt_src.
- R9: A cfg_we write while idle loads cfg_field, and cmp_value shows the new value on the next cycle.
- R10: With CNT_W = 19, the field is 15 bits wide. The count reaches compare values above 0xFFFF and completes as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the oscillator being warmed up |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the compare field |
| cfg_field | input | CNT_W-4 | Upper bits of the compare value |
| sw_start | input | 1 | Software start request, one-cycle pulse |
| sw_src | input | 1 | Source chosen by software: 0 external, 1 internal |
| wake_start | input | 1 | Start request from the power-mode controller on deep-stop exit |
| busy | output | 1 | Count in progress (start bit readback) |
| done | output | 1 | One-cycle completion pulse |
| count | output | CNT_W | Current counter value |
| cmp_value | output | CNT_W | Full compare value, low nibble zero |
| cnt_src | output | 1 | Source in use for the current count: 0 external, 1 internal |

## Verification
A corrupted counter or compare register shows up at the count and cmp_value ports within the next cycle, because the bench model compares both on every clock. A wrong busy state or hit detection shows up as a busy window of the wrong length, or as done arriving one cycle early or late, at the completion edge. A start or field write leaking through while busy shows as count falling back to zero, or as cmp_value changing in mid-count, in the cycle after the request. A source latch error shows on cnt_src from the first busy cycle.

// File: rtl/wut_pkg.sv
package wut_pkg;
  localparam int unsigned WUT_LOW_BITS = 4;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } wut_src_e;
endpackage

// File: rtl/wut_cfg.sv
module wut_cfg #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned LOW_BITS  = 4,
  parameter int unsigned RST_FIELD = 'h800,
  localparam int unsigned FIELD_W  = CNT_W - LOW_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               busy,
  input  logic [FIELD_W-1:0] field_in,
  output logic [CNT_W-1:0]   cmp_out
);
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= FIELD_W'(RST_FIELD);
    end else if (we && !busy) begin
      field_q <= field_in;
    end
  end

  generate
    if (LOW_BITS == 0) begin : g_nolow
      assign cmp_out = field_q;
    end else begin : g_low
      assign cmp_out = {field_q, {LOW_BITS{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/wut_count.sv
module wut_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign hit = (cnt_q == cmp);
endmodule

// File: rtl/wut_ctrl.sv
module wut_ctrl
  import wut_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sw_start,
  input  logic     sw_src,
  input  logic     wake_start,
  input  logic     hit,
  output logic     busy,
  output logic     done,
  output wut_src_e src,
  output logic     clr,
  output logic     run
);
  logic     busy_q;
  logic     done_q;
  wut_src_e src_q;
  logic     start_acc;
  wut_src_e src_next;

  assign start_acc = (sw_start || wake_start) && !busy_q;
  assign src_next  = wake_start ? SRC_INT : wut_src_e'(sw_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      src_q  <= SRC_EXT;
    end else begin
      done_q <= busy_q && hit;
      if (start_acc) begin
        busy_q <= 1'b1;
        src_q  <= src_next;
      end else if (busy_q && hit) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign src  = src_q;
  assign clr  = start_acc;
  assign run  = busy_q && !hit;
endmodule

// File: rtl/wut_top.sv
module wut_top
  import wut_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RST_FIELD = 'h800,
  localparam int unsigned FIELD_W  = CNT_W - WUT_LOW_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic               sw_start,
  input  logic               sw_src,
  input  logic               wake_start,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   cmp_value,
  output logic               cnt_src
);
  logic     hit;
  logic     clr;
  logic     run;
  wut_src_e src;

  wut_cfg #(
    .CNT_W    (CNT_W),
    .LOW_BITS (WUT_LOW_BITS),
    .RST_FIELD(RST_FIELD)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .busy    (busy),
    .field_in(cfg_field),
    .cmp_out (cmp_value)
  );

  wut_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .sw_src    (sw_src),
    .wake_start(wake_start),
    .hit       (hit),
    .busy      (busy),
    .done      (done),
    .src       (src),
    .clr       (clr),
    .run       (run)
  );

  wut_count #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .run  (run),
    .cmp  (cmp_value),
    .cnt  (count),
    .hit  (hit)
  );

  assign cnt_src = logic'(src);
endmodule

// File: rtl/wut_chk.sv
module wut_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wake_start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_value,
  input logic             cnt_src
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (count == CNT_W'($past(count) + 1'b1))); // R5
  AST_DONE_AT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == cmp_value)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(count)); // R6
  AST_CMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmp_value)); // R7
  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_src)); // R8
  AST_WAKE_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(wake_start)) |-> cnt_src); // R4
endmodule

bind wut_top wut_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .wake_start(wake_start),
  .count     (count),
  .cmp_value (cmp_value),
  .cnt_src   (cnt_src)
);

// File: tb/sim_wut_top.sv
module sim_wut_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [14:0] cfg_field = '0;
  logic        sw_start = 1'b0;
  logic        sw_src = 1'b0;
  logic        wake_start = 1'b0;

  logic        busy0, done0, src0;
  logic [15:0] cnt0, cmp0;
  logic        busy1, done1, src1;
  logic [18:0] cnt1, cmp1;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 1'b0;

  // behavioural model, index 0 = 16-bit, 1 = 19-bit
  int m_busy[2], m_done[2], m_cnt[2], m_field[2], m_src[2];

  always #(CLK_P/2) clk = ~clk;

  wut_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field[11:0]),
    .sw_start(sw_start), .sw_src(sw_src), .wake_start(wake_start),
    .busy(busy0), .done(done0), .count(cnt0), .cmp_value(cmp0), .cnt_src(src0)
  );

  wut_top #(.CNT_W(19)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .sw_start(sw_start), .sw_src(sw_src), .wake_start(wake_start),
    .busy(busy1), .done(done1), .count(cnt1), .cmp_value(cmp1), .cnt_src(src1)
  );

  function automatic int mcmp(int i);
    return m_field[i] * 16;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_busy[i] = 0; m_done[i] = 0; m_cnt[i] = 0; m_src[i] = 0;
        m_field[i] = 'h800;
      end else begin
        bit hitv;
        bit st;
        hitv = (m_cnt[i] == mcmp(i));
        st = (sw_start || wake_start) && (m_busy[i] == 0);
        m_done[i] = (m_busy[i] != 0 && hitv) ? 1 : 0;
        if (cfg_we && m_busy[i] == 0)
          m_field[i] = (i == 0) ? int'(cfg_field[11:0]) : int'(cfg_field);
        if (st) begin
          m_busy[i] = 1; m_cnt[i] = 0;
          m_src[i] = wake_start ? 1 : int'(sw_src);
        end else if (m_busy[i] != 0) begin
          if (hitv) m_busy[i] = 0;
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 busy u0", int'(busy0), m_busy[0]);
      chk("R5 done u0", int'(done0), m_done[0]);
      chk("R6 count u0", int'(cnt0), m_cnt[0]);
      chk("R9 cmp u0", int'(cmp0), mcmp(0));
      chk("R4 src u0", int'(src0), m_src[0]);
      chk("R10 busy u1", int'(busy1), m_busy[1]);
      chk("R10 done u1", int'(done1), m_done[1]);
      chk("R10 count u1", int'(cnt1), m_cnt[1]);
      chk("R10 cmp u1", int'(cmp1), mcmp(1));
      chk("R10 src u1", int'(src1), m_src[1]);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG);
        finish_run();
      end
    end
  end

  task automatic write_field(int v);
    cfg_field = 15'(v); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic start_sw(bit s);
    sw_src = s; sw_start = 1'b1;
    step();
    sw_start = 1'b0; sw_src = 1'b0;
  endtask

  initial begin
    int n;
    step(); step();
    // R1 reset state
    chk("R1 busy", int'(busy0), 0);
    chk("R1 done", int'(done0), 0);
    chk("R1 count", int'(cnt0), 0);
    chk("R1 cmp", int'(cmp0), 'h8000);
    chk("R1 src", int'(src0), 0);
    rst_n = 1'b1;
    step();

    // R9 / R2 field load while idle
    write_field('h003);
    chk("R9 cmp loaded", int'(cmp0), 'h30);
    chk("R2 low nibble zero", int'(cmp0[3:0]), 0);
    write_field('hABC);
    chk("R2 shift", int'(cmp0), 'hABC0);
    write_field('h003);

    // R3 / R5 / R6 software start with external source
    start_sw(1'b0);
    chk("R3 busy after start", int'(busy0), 1);
    chk("R3 count cleared", int'(cnt0), 0);
    chk("R3 src from software", int'(src0), 0);
    n = 0;
    while (busy0) begin n++; step(); end
    chk("R5 busy length", n, 'h31);
    chk("R5 done with busy low", int'(done0), 1);
    step();
    chk("R5 done one cycle", int'(done0), 0);
    chk("R6 count held", int'(cnt0), 'h30);
    step(); step();
    chk("R6 count still held", int'(cnt0), 'h30);

    // R7 / R8 writes and restarts while busy
    start_sw(1'b1);
    chk("R3 src internal by software", int'(src0), 1);
    step(); step();
    write_field('h005);
    chk("R7 cmp unchanged", int'(cmp0), 'h30);
    n = int'(cnt0);
    sw_start = 1'b1; sw_src = 1'b0; step(); sw_start = 1'b0;
    chk("R8 no restart", int'(cnt0), n + 1);
    chk("R8 src unchanged", int'(src0), 1);
    wake_start = 1'b1; step(); wake_start = 1'b0;
    chk("R8 wake ignored", int'(cnt0), n + 2);
    while (busy0) step();
    step();
    chk("R7 field kept", int'(cmp0), 'h30);

    // R4 wake start wins source
    wake_start = 1'b1; sw_start = 1'b1; sw_src = 1'b0;
    step();
    wake_start = 1'b0; sw_start = 1'b0;
    chk("R4 busy", int'(busy0), 1);
    chk("R4 src internal", int'(src0), 1);
    while (busy0) step();
    step();

    // R5 zero compare
    write_field('h000);
    start_sw(1'b0);
    n = 0;
    while (busy0) begin n++; step(); end
    chk("R5 zero compare length", n, 1);
    chk("R5 zero compare done", int'(done0), 1);
    step();

    // R10 wide variant above 0xFFFF
    write_field('h1002);
    chk("R10 wide cmp", int'(cmp1), 'h10020);
    chk("R10 narrow cmp", int'(cmp0), 'h20);
    start_sw(1'b0);
    n = 0;
    while (busy1) begin n++; step(); end
    chk("R10 wide length", n, 'h10021);
    chk("R10 wide done", int'(done1), 1);
    chk("R10 wide count", int'(cnt1), 'h10020);
    step();
    finish_run();
  end
endmodule